// File: doc/BRIEF.md
# Indirect Per-Channel Block Pointer Access

This block sits behind a host register port and gives the host indirect access to a small table of buffer block pointers, one entry pair per channel, for 40 channels. Each entry holds a 9-bit starting block and a 9-bit current block. The current block is the one the receive path is writing into at that moment. The host does not address the table directly. It writes a select register that names a channel and a direction. It then watches a busy flag until the access has finished. Data moves through a separate 16-bit data register.

An indirect write takes the value already held in the data register and stores it as the channel's starting block. The same value also becomes the channel's current block. An indirect read copies the channel's live current block into the data register. Each access finishes a fixed number of cycles after the select write. This delay stands for the latency of a table memory.

The receive data path has an update strobe that moves a channel's current block to a new value. It also has a combinational lookup that returns a channel's starting block.

Top module: `ipa_ptr_access`

## Requirements
- R1: The select register sits at offset 0x900. A host write places the channel code from bits 5:0 and the direction from bit 14 into it; the direction is 1 for read and 0 for write. Code 0x00 names channel 1 and code 0x27 names channel 40. Reading offset 0x900 returns the busy flag in bit 15, the direction in bit 14 and the code in bits 5:0.
- R2: The data register sits at offset 0x904. A host write stores bits 8:0 as a block number from 0x000 to 0x1FF, and a read returns it in bits 8:0.
- R3: A select write made while busy is 0 starts an access. Busy reads as 1 in the next cycle and stays 1 for exactly 2 cycles, then returns to 0.
- R4: A select write made while busy is 1 is ignored. The stored code and direction keep their values, and the running access finishes on its original schedule.
- R5: When an indirect write finishes, the data register value becomes both the starting block and the current block of the selected channel. Every value from 0x000 to 0x1FF is accepted.
- R6: When an indirect read finishes, the data register holds the selected channel's current block as it was in that cycle. This read result takes precedence over a host data write made in the same cycle.
- R7: While the update strobe is high, the addressed channel's current block takes the supplied value in the next cycle. If an indirect write to the same channel finishes in that cycle, the host value wins.
- R8: A channel code above 0x27 still runs the full busy handshake but changes no table entry. An indirect read of such a code loads 0 into the data register.
- R9: Reserved bits read as 0. Bits 13:6 of the select register and bits 15:9 of the data register read as 0, any other offset reads 0, and reset clears every register and every pointer.
- R10: The start lookup output gives, without delay, the starting block of the channel named on the lookup code. For a code above 0x27 it gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 12 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the offset on host_addr |
| dp_upd | input | 1 | Data-path strobe that sets a current block |
| dp_chan | input | 6 | Channel code for the update and for the start lookup |
| dp_ptr | input | 9 | New current block for the update |
| dp_start | output | 9 | Starting block of the channel on dp_chan |

## Verification
The assertions assume that the host makes at most one register write per cycle and drives host_addr with a settled offset. They also assume that dp_chan is a stable code during a cycle, though it may be out of range. The ignored-write check further assumes the host may write the select register at any time, busy or not. The stimulus drives inputs only at the falling edge and holds each host write for exactly one cycle. It deliberately places select writes inside busy windows and lines up an update strobe with the cycle in which an indirect write finishes. The stimulus also uses codes above 0x27 on both the host side and the data-path side, which keeps every assumption met while reaching the corner cases.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
   localparam int SEL_DIR_BIT  = 14;
   localparam int SEL_BUSY_BIT = 15;

   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } acc_dir_e;
endpackage

// File: rtl/ipa_seq.sv
module ipa_seq #(
   parameter int ACC_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic commit
);
   localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;

   logic busy_q;
   assign busy = busy_q;

   generate
      if (ACC_LAT == 1) begin : g_single
         assign commit = busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       busy_q <= 1'b0;
            else if (start)   busy_q <= 1'b1;
            else if (commit)  busy_q <= 1'b0;
         end
      end else begin : g_count
         logic [CNT_W-1:0] left_q;
         assign commit = busy_q && (left_q == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               left_q <= '0;
            end else if (start) begin
               busy_q <= 1'b1;
               left_q <= CNT_W'(ACC_LAT - 1);
            end else if (commit) begin
               busy_q <= 1'b0;
            end else if (busy_q) begin
               left_q <= left_q - 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ipa_ptr_table.sv
module ipa_ptr_table #(
   parameter int NUM_CH = 40,
   parameter int ID_W   = 6,
   parameter int PTR_W  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [ID_W-1:0]  host_ch,
   input  logic [PTR_W-1:0] host_ptr,
   input  logic             dp_we,
   input  logic [ID_W-1:0]  dp_ch,
   input  logic [PTR_W-1:0] dp_ptr,
   input  logic [ID_W-1:0]  rd_ch,
   output logic [PTR_W-1:0] rd_cur,
   input  logic [ID_W-1:0]  look_ch,
   output logic [PTR_W-1:0] look_start
);
   logic [PTR_W-1:0] cur_arr   [NUM_CH];
   logic [PTR_W-1:0] start_arr [NUM_CH];

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic [PTR_W-1:0] start_q;
         logic [PTR_W-1:0] cur_q;
         logic             h_hit;
         logic             d_hit;
         assign h_hit = host_we && (host_ch == ID_W'(i));
         assign d_hit = dp_we && (dp_ch == ID_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               start_q <= '0;
               cur_q   <= '0;
            end else if (h_hit) begin
               start_q <= host_ptr;
               cur_q   <= host_ptr;
            end else if (d_hit) begin
               cur_q   <= dp_ptr;
            end
         end
         assign cur_arr[i]   = cur_q;
         assign start_arr[i] = start_q;
      end
   endgenerate

   always_comb begin
      rd_cur = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (rd_ch == ID_W'(i)) rd_cur = cur_arr[i];
   end

   always_comb begin
      look_start = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (look_ch == ID_W'(i)) look_start = start_arr[i];
   end
endmodule

// File: rtl/ipa_host_regs.sv
module ipa_host_regs
   import ipa_pkg::*;
#(
   parameter int              ADDR_W   = 12,
   parameter int              DATA_W   = 16,
   parameter int              ID_W     = 6,
   parameter int              PTR_W    = 9,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 12'h900,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 12'h904
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              busy,
   input  logic              commit,
   input  logic [PTR_W-1:0]  rd_value,
   output logic              sel_start,
   output logic [ID_W-1:0]   sel_ch,
   output acc_dir_e          sel_dir,
   output logic [PTR_W-1:0]  data_q
);
   logic sel_hit;
   logic dat_hit;
   logic rd_load;
   logic unused_wbits;

   assign sel_hit   = (host_addr == SEL_ADDR);
   assign dat_hit   = (host_addr == DAT_ADDR);
   assign sel_start = host_wr && sel_hit && !busy;
   assign rd_load   = commit && (sel_dir == DIR_READ);
   assign unused_wbits = ^host_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_ch  <= '0;
         sel_dir <= DIR_WRITE;
      end else if (sel_start) begin
         sel_ch  <= host_wdata[ID_W-1:0];
         sel_dir <= acc_dir_e'(host_wdata[SEL_DIR_BIT]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  data_q <= '0;
      else if (rd_load)            data_q <= rd_value;
      else if (host_wr && dat_hit) data_q <= host_wdata[PTR_W-1:0];
   end

   always_comb begin
      host_rdata = '0;
      if (sel_hit) begin
         host_rdata[ID_W-1:0]     = sel_ch;
         host_rdata[SEL_DIR_BIT]  = sel_dir;
         host_rdata[SEL_BUSY_BIT] = busy;
      end else if (dat_hit) begin
         host_rdata[PTR_W-1:0]    = data_q;
      end
   end
endmodule

// File: rtl/ipa_ptr_access.sv
module ipa_ptr_access
   import ipa_pkg::*;
#(
   parameter int              NUM_CH   = 40,
   parameter int              ID_W     = 6,
   parameter int              PTR_W    = 9,
   parameter int              ADDR_W   = 12,
   parameter int              DATA_W   = 16,
   parameter int              ACC_LAT  = 2,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 12'h900,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 12'h904
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              dp_upd,
   input  logic [ID_W-1:0]   dp_chan,
   input  logic [PTR_W-1:0]  dp_ptr,
   output logic [PTR_W-1:0]  dp_start
);
   generate
      if (NUM_CH < 1 || NUM_CH > (1 << ID_W)) begin : g_bad_ch
         $error("NUM_CH does not fit the channel code width");
      end
      if (ID_W > SEL_DIR_BIT) begin : g_bad_id
         $error("channel code overlaps the direction bit");
      end
      if (PTR_W > DATA_W || DATA_W <= SEL_BUSY_BIT) begin : g_bad_data
         $error("register width too small for its fields");
      end
      if (ACC_LAT < 1) begin : g_bad_lat
         $error("ACC_LAT must be at least 1");
      end
   endgenerate

   logic             sel_start;
   logic             busy;
   logic             commit;
   logic [ID_W-1:0]  sel_ch;
   acc_dir_e         sel_dir;
   logic [PTR_W-1:0] data_q;
   logic [PTR_W-1:0] rd_cur;
   logic             tbl_we;

   assign tbl_we = commit && (sel_dir == DIR_WRITE);

   ipa_host_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .PTR_W(PTR_W),
      .SEL_ADDR(SEL_ADDR), .DAT_ADDR(DAT_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
      .commit(commit), .rd_value(rd_cur), .sel_start(sel_start),
      .sel_ch(sel_ch), .sel_dir(sel_dir), .data_q(data_q)
   );

   ipa_seq #(.ACC_LAT(ACC_LAT)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(sel_start), .busy(busy), .commit(commit)
   );

   ipa_ptr_table #(.NUM_CH(NUM_CH), .ID_W(ID_W), .PTR_W(PTR_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .host_we(tbl_we), .host_ch(sel_ch),
      .host_ptr(data_q), .dp_we(dp_upd), .dp_ch(dp_chan), .dp_ptr(dp_ptr),
      .rd_ch(sel_ch), .rd_cur(rd_cur), .look_ch(dp_chan), .look_start(dp_start)
   );
endmodule

// File: rtl/ipa_ptr_access_chk.sv
module ipa_ptr_access_chk #(
   parameter int              NUM_CH   = 40,
   parameter int              ID_W     = 6,
   parameter int              PTR_W    = 9,
   parameter int              ADDR_W   = 12,
   parameter int              DATA_W   = 16,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 12'h900,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 12'h904
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_rdata,
   input logic              busy,
   input logic              commit,
   input logic              sel_dir,
   input logic [ID_W-1:0]   sel_ch,
   input logic [PTR_W-1:0]  data_q,
   input logic [ID_W-1:0]   dp_chan,
   input logic [PTR_W-1:0]  dp_start
);
   localparam logic [ID_W:0] CH_LIM = (ID_W+1)'(NUM_CH);

   p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == SEL_ADDR && !busy) |=> busy);

   p_busy_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !busy);

   p_busy_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_wr && host_addr == SEL_ADDR) |=> ($stable(sel_ch) && $stable(sel_dir)));

   p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && sel_dir && {1'b0, sel_ch} >= CH_LIM) |=> (data_q == '0));

   p_data_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == DAT_ADDR) |-> (host_rdata[DATA_W-1:PTR_W] == '0));

   p_sel_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == SEL_ADDR) |-> (host_rdata[13:ID_W] == '0));

   p_lookup_oob_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, dp_chan} >= CH_LIM) |-> (dp_start == '0));
endmodule

bind ipa_ptr_access ipa_ptr_access_chk #(
   .NUM_CH(NUM_CH), .ID_W(ID_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR), .DAT_ADDR(DAT_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
   .host_rdata(host_rdata), .busy(busy), .commit(commit), .sel_dir(sel_dir),
   .sel_ch(sel_ch), .data_q(data_q), .dp_chan(dp_chan), .dp_start(dp_start)
);

// File: tb/ipa_ptr_access_bench.sv
module ipa_ptr_access_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [11:0] host_addr = 12'h000;
   logic [15:0] host_wdata = 16'h0000;
   logic [15:0] host_rdata;
   logic        dp_upd = 1'b0;
   logic [5:0]  dp_chan = 6'd0;
   logic [8:0]  dp_ptr = 9'd0;
   logic [8:0]  dp_start;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipa_ptr_access u_ipa_ptr_access (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .dp_upd(dp_upd),
      .dp_chan(dp_chan), .dp_ptr(dp_ptr), .dp_start(dp_start)
   );

   int vectors = 0;
   int miscompares = 0;
   string tag = "R9";

   int       m_rem;
   int       m_ch;
   int       m_dir;
   int       m_data;
   int       m_start [NCH];
   int       m_cur   [NCH];

   task automatic model_reset();
      m_rem = 0; m_ch = 0; m_dir = 0; m_data = 0;
      for (int i = 0; i < NCH; i++) begin
         m_start[i] = 0;
         m_cur[i] = 0;
      end
   endtask

   task automatic model_edge();
      bit fin;
      bit old_busy;
      int old_data;
      int ch_now;
      old_busy = (m_rem > 0);
      old_data = m_data;
      fin = 1'b0;
      if (m_rem > 0) begin
         m_rem--;
         if (m_rem == 0) fin = 1'b1;
      end
      if (fin && m_dir == 1)
         m_data = (m_ch < NCH) ? m_cur[m_ch] : 0;
      else if (host_wr && host_addr == 12'h904)
         m_data = int'(host_wdata[8:0]);
      if (fin && m_dir == 0 && m_ch < NCH) begin
         m_start[m_ch] = old_data;
         m_cur[m_ch] = old_data;
      end
      ch_now = int'(dp_chan);
      if (dp_upd && ch_now < NCH && !(fin && m_dir == 0 && m_ch == ch_now))
         m_cur[ch_now] = int'(dp_ptr);
      if (host_wr && host_addr == 12'h900 && !old_busy) begin
         m_ch = int'(host_wdata[5:0]);
         m_dir = int'(host_wdata[14]);
         m_rem = 2;
      end
   endtask

   function automatic logic [15:0] exp_rdata();
      logic [15:0] v;
      v = 16'h0000;
      if (host_addr == 12'h900) begin
         v[5:0] = 6'(m_ch);
         v[14] = (m_dir == 1);
         v[15] = (m_rem > 0);
      end else if (host_addr == 12'h904) begin
         v[8:0] = 9'(m_data);
      end
      return v;
   endfunction

   function automatic logic [8:0] exp_start();
      return (int'(dp_chan) < NCH) ? 9'(m_start[int'(dp_chan)]) : 9'd0;
   endfunction

   task automatic compare();
      vectors++;
      if (host_rdata !== exp_rdata()) begin
         miscompares++;
         $display("FAIL %s host_rdata addr=%h actual=%h expected=%h",
                  tag, host_addr, host_rdata, exp_rdata());
      end
      vectors++;
      if (dp_start !== exp_start()) begin
         miscompares++;
         $display("FAIL R10 (%s) dp_start chan=%h actual=%h expected=%h",
                  tag, dp_chan, dp_start, exp_start());
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic hwrite(input logic [11:0] a, input logic [15:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      cyc();
      host_wr = 1'b0;
   endtask

   task automatic watch(input logic [11:0] a);
      host_addr = a;
      #1;
      compare();
   endtask

   task automatic access(input int ch, input int rd, input int val);
      if (rd == 0) hwrite(12'h904, 16'(val));
      hwrite(12'h900, 16'((rd << 14) | ch));
      idle(1);
      watch(12'h900);
      idle(2);
      watch(12'h904);
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      tag = "R9";
      watch(12'h900);
      watch(12'h904);
      dp_chan = 6'd5;
      watch(12'h904);
      rst_n = 1'b1;
      idle(1);

      tag = "R2";
      hwrite(12'h904, 16'hFE5A);
      watch(12'h904);
      tag = "R9";
      watch(12'h910);
      watch(12'h000);

      tag = "R5";
      dp_chan = 6'd0;
      access(0, 0, 16'h01FF);
      idle(1);
      tag = "R6";
      access(0, 1, 0);
      tag = "R5";
      dp_chan = 6'd39;
      access(39, 0, 16'h00AA);
      access(17, 0, 16'h0000);
      tag = "R6";
      access(39, 1, 0);

      tag = "R1";
      hwrite(12'h900, 16'hFFD3);
      watch(12'h900);
      idle(3);
      watch(12'h900);
      watch(12'h904);

      tag = "R4";
      hwrite(12'h904, 16'h0123);
      hwrite(12'h900, 16'h0003);
      hwrite(12'h900, 16'h4005);
      watch(12'h900);
      hwrite(12'h900, 16'h4007);
      watch(12'h900);
      idle(2);
      watch(12'h900);
      dp_chan = 6'd3;
      watch(12'h904);

      tag = "R7";
      dp_upd = 1'b1; dp_chan = 6'd3; dp_ptr = 9'h155;
      cyc();
      dp_upd = 1'b0;
      access(3, 1, 0);
      watch(12'h904);

      tag = "R7";
      hwrite(12'h904, 16'h0077);
      hwrite(12'h900, 16'h0008);
      idle(1);
      dp_upd = 1'b1; dp_chan = 6'd8; dp_ptr = 9'h1E0;
      cyc();
      dp_upd = 1'b0;
      access(8, 1, 0);

      tag = "R6";
      hwrite(12'h900, 16'h4003);
      idle(1);
      hwrite(12'h904, 16'h0099);
      watch(12'h904);

      tag = "R8";
      dp_chan = 6'd40;
      access(40, 0, 16'h0111);
      access(40, 1, 0);
      dp_chan = 6'd63;
      access(63, 1, 0);
      dp_chan = 6'd0;
      access(0, 1, 0);

      tag = "R3";
      for (int k = 0; k < 6; k++) begin
         dp_upd = 1'b1; dp_chan = 6'(k * 7); dp_ptr = 9'(k * 83 + 5);
         cyc();
      end
      dp_upd = 1'b0;
      for (int k = 0; k < 6; k++) access(k * 7, 1, 0);

      tag = "R9";
      rst_n = 1'b0;
      model_reset();
      #1;
      watch(12'h904);
      watch(12'h900);
      rst_n = 1'b1;
      dp_chan = 6'd39;
      idle(1);
      access(39, 1, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule